// File: doc/BRIEF.md
# Receive Frame FIFO with Packet Counter

This block sits between a receive byte stream and a software-visible data register. Frames arrive as a byte stream carrying start, end and error markers. Each frame is packed into a word-wide buffer. The first word of a stored frame carries a 16-bit length field and the first two frame bytes. The frame's remaining bytes follow in later words, least significant byte first. The length is only known once the last byte has arrived, so the first word is written in a separate sealing cycle after the end-of-frame beat. The frame becomes visible to the reader only after that cycle.

A counter of complete frames drives the receive interrupt and gates the read port. The reader is offered a word only while at least one whole frame is stored. The counter falls when the last word of the oldest frame is popped. A frame that would not fit in the free space is dropped: the write position returns to the frame's start and a sticky overflow flag is set. A frame marked with the error strobe is also dropped, but without setting the flag. A synchronous clear control empties the buffer and clears the counter and the flag.

Both streams are valid/ready. A receive beat is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops only for the single sealing cycle after an end-of-frame beat. A word is popped on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_data` holds its value. The buffer depth must be a power of two.

Top module: `rx_frame_fifo`

## Requirements
- R1: In the first word of a stored frame, bits 15:0 hold the length, bits 23:16 hold frame byte 0 and bits 31:24 hold frame byte 1. A one-byte frame has zero in bits 31:24.
- R2: The stored length equals the number of frame bytes received plus 2.
- R3: Frame byte k (k >= 2) sits in word (k+2)/4 at bit lane 8*((k+2)%4). Lanes past the frame's last byte in its final word read as zero.
- R4: After an accepted end-of-frame beat, `in_ready` is low for the next cycle and `pkt_count` still holds its old value. At the following edge `pkt_count` rises by one.
- R5: `out_valid` is high only while `pkt_count` is nonzero. A frame of L stored length takes ceil(L/4) pops. `pkt_count` drops by one on the edge that pops the frame's last word and not earlier.
- R6: `rx_irq` is high exactly when `pkt_count` is nonzero.
- R7: A frame needing more words than are free is discarded. `ovf_flag` is set and stays set until a clear. `pkt_count` is unchanged, frames stored earlier read back intact, and the freed space is reused by the next frame. A frame that exactly fills the free space is accepted.
- R8: A frame with `in_err` high on any of its beats, including the end beat, is discarded without setting `ovf_flag`.
- R9: Holding `fifo_clear` high for one cycle leaves `pkt_count` at 0, `out_valid` low and `ovf_flag` low.
- R10: Beats accepted outside a frame are ignored. A start-of-frame beat inside a frame drops the partial frame and starts a new one.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` does not change.
- R12: After reset, `pkt_count` is 0, `rx_irq`, `out_valid` and `ovf_flag` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clear | input | 1 | Synchronous clear of stored frames, count and flag |
| in_valid | input | 1 | Receive byte valid |
| in_ready | output | 1 | Receive byte accepted this edge when high |
| in_data | input | 8 | Receive byte |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_err | input | 1 | Frame carrying this beat is bad |
| out_valid | output | 1 | A word of a complete frame is offered |
| out_ready | input | 1 | Reader pops the offered word |
| out_data | output | 32 | Word at the read position |
| pkt_count | output | clog2(DEPTH_WORDS+1) | Complete frames stored |
| rx_irq | output | 1 | Receive interrupt, frames waiting |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench drives frames of one to six bytes, where the header word's partial lanes and the final partial word are easiest to mis-pack. A packing slip would show up as a shifted byte or stale data in unused lanes. It places the counter checks around the sealing cycle and the final pop, so a design that counts at the end beat or decrements on the header pop is caught. It fills the buffer to exactly its last word and then one byte past it. An off-by-one in the space test would either reject the exact fit or overwrite the unread frame. Error-marked frames, stray beats and mid-frame restarts are each followed by a clean frame that must read back byte-exact, which exposes a write position that was not rewound.

// File: rtl/rx_frame_fifo_pkg.sv
package rx_frame_fifo_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;
  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {W_IDLE, W_RECV, W_DROP, W_SEAL} wr_state_e;

  // words occupied by a stored frame of the given length field
  function automatic logic [LEN_W:0] words_in(input logic [LEN_W-1:0] len);
    return ({1'b0, len} + (LEN_W+1)'(LANES - 1)) >> LANE_W;
  endfunction
endpackage

// File: rtl/rff_ram.sv
module rff_ram #(
  parameter int DEPTH  = 512,
  parameter int WIDTH  = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rff_wr_pack.sv
module rff_wr_pack import rx_frame_fifo_pkg::*; #(
  parameter int DEPTH = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [BYTE_W-1:0]          in_data,
  input  logic                       in_sof,
  input  logic                       in_eof,
  input  logic                       in_err,
  input  logic [$clog2(DEPTH):0]     rd_ptr,
  output logic                       we,
  output logic [$clog2(DEPTH)-1:0]   waddr,
  output logic [WORD_W-1:0]          wdata,
  output logic                       commit,
  output logic                       ovf_flag
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int P_W    = ADDR_W + 1;

  wr_state_e         state;
  logic [P_W-1:0]    wr_base, wptr, next_free;
  logic [LANE_W-1:0] lane;
  logic [WORD_W-1:0] acc;
  logic [BYTE_W-1:0] hb0, hb1;
  logic [LEN_W-1:0]  nbytes;

  logic              beat, new_frame, taking, in_word0, need_alloc, space_ok, ovf_hit;
  logic [P_W-1:0]    pos_ptr, fill;
  logic [LANE_W-1:0] pos_lane;
  logic [WORD_W-1:0] acc_n;

  assign in_ready = (state != W_SEAL);
  assign commit   = (state == W_SEAL);

  always_comb begin
    beat       = in_valid && in_ready;
    new_frame  = beat && in_sof;
    taking     = new_frame || (beat && state == W_RECV);
    pos_ptr    = new_frame ? wr_base : wptr;
    pos_lane   = new_frame ? LANE_W'(2) : lane;
    in_word0   = (pos_ptr == wr_base);
    fill       = pos_ptr - rd_ptr;
    need_alloc = new_frame || (pos_lane == '0);
    space_ok   = (fill < P_W'(DEPTH));
    ovf_hit    = taking && !in_err && need_alloc && !space_ok;
    for (int b = 0; b < LANES; b++) begin
      if (LANE_W'(b) == pos_lane)
        acc_n[BYTE_W*b +: BYTE_W] = in_data;
      else if (LANE_W'(b) < pos_lane && !new_frame)
        acc_n[BYTE_W*b +: BYTE_W] = acc[BYTE_W*b +: BYTE_W];
      else
        acc_n[BYTE_W*b +: BYTE_W] = '0;
    end
  end

  // data words are written as they fill; the header word is sealed last
  always_comb begin
    if (state == W_SEAL) begin
      we    = 1'b1;
      waddr = wr_base[ADDR_W-1:0];
      wdata = {hb1, hb0, nbytes + LEN_W'(2)};
    end else begin
      we    = taking && !in_err && !ovf_hit && !in_word0 &&
              ((pos_lane == LANE_W'(LANES - 1)) || in_eof);
      waddr = pos_ptr[ADDR_W-1:0];
      wdata = acc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      state     <= W_IDLE;
      wr_base   <= '0;
      wptr      <= '0;
      next_free <= '0;
      lane      <= '0;
      acc       <= '0;
      hb0       <= '0;
      hb1       <= '0;
      nbytes    <= '0;
      ovf_flag  <= 1'b0;
    end else begin
      if (ovf_hit) ovf_flag <= 1'b1;
      if (state == W_SEAL) begin
        wr_base <= next_free;
        state   <= W_IDLE;
      end else if (taking) begin
        if (in_err || ovf_hit) begin
          state <= in_eof ? W_IDLE : W_DROP;
        end else begin
          acc  <= acc_n;
          lane <= pos_lane + 1'b1;
          wptr <= (pos_lane == LANE_W'(LANES - 1)) ? pos_ptr + 1'b1 : pos_ptr;
          if (new_frame) begin
            hb0    <= in_data;
            hb1    <= '0;
            nbytes <= LEN_W'(1);
          end else begin
            nbytes <= nbytes + 1'b1;
            if (in_word0 && pos_lane == LANE_W'(LANES - 1)) hb1 <= in_data;
          end
          if (in_eof) begin
            state     <= W_SEAL;
            next_free <= pos_ptr + 1'b1;
          end else begin
            state <= W_RECV;
          end
        end
      end else if (beat && state == W_DROP && in_eof) begin
        state <= W_IDLE;
      end
    end
  end

  logic [P_W-1:0] used_words;
  assign used_words = wr_base - rd_ptr;

  AST_OCCUPANCY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used_words <= P_W'(DEPTH)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr) |=> ovf_flag); // R7
  AST_SEAL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && in_eof && !in_err && !ovf_hit && taking && !clr) |=> !in_ready); // R4
endmodule

// File: rtl/rff_rd_track.sv
module rff_rd_track import rx_frame_fifo_pkg::*; #(
  parameter int DEPTH = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       commit,
  input  logic                       out_ready,
  input  logic [LEN_W-1:0]           head_len,
  output logic                       out_valid,
  output logic [$clog2(DEPTH+1)-1:0] pkt_count,
  output logic [$clog2(DEPTH):0]     rd_ptr
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             at_head;
  logic [LEN_W:0]   remain, head_words;
  logic             pop, last;

  assign out_valid  = (pkt_count != '0);
  assign pop        = out_valid && out_ready;
  assign head_words = words_in(head_len);
  assign last       = at_head ? (head_words == (LEN_W+1)'(1)) : (remain == (LEN_W+1)'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      pkt_count <= '0;
      rd_ptr    <= '0;
      at_head   <= 1'b1;
      remain    <= '0;
    end else begin
      if (commit && !(pop && last))      pkt_count <= pkt_count + 1'b1;
      else if (!commit && pop && last)   pkt_count <= pkt_count - 1'b1;
      if (pop) begin
        rd_ptr <= rd_ptr + 1'b1;
        if (last) begin
          at_head <= 1'b1;
        end else if (at_head) begin
          at_head <= 1'b0;
          remain  <= head_words - 1'b1;
        end else begin
          remain  <= remain - 1'b1;
        end
      end
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (pkt_count == $past(pkt_count) ||
              pkt_count == $past(pkt_count) + CNT_W'(1) ||
              pkt_count == $past(pkt_count) - CNT_W'(1))); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_count <= CNT_W'(DEPTH)); // R5
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo import rx_frame_fifo_pkg::*; #(
  parameter int DEPTH_WORDS = 512
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             fifo_clear,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [7:0]                       in_data,
  input  logic                             in_sof,
  input  logic                             in_eof,
  input  logic                             in_err,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [31:0]                      out_data,
  output logic [$clog2(DEPTH_WORDS+1)-1:0] pkt_count,
  output logic                             rx_irq,
  output logic                             ovf_flag
);
  localparam int ADDR_W = $clog2(DEPTH_WORDS);

  logic                we, commit;
  logic [ADDR_W-1:0]   waddr;
  logic [WORD_W-1:0]   wdata;
  logic [ADDR_W:0]     rd_ptr;

  rff_wr_pack #(.DEPTH(DEPTH_WORDS)) u_wr (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clear),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
    .rd_ptr(rd_ptr), .we(we), .waddr(waddr), .wdata(wdata),
    .commit(commit), .ovf_flag(ovf_flag)
  );

  rff_ram #(.DEPTH(DEPTH_WORDS), .WIDTH(WORD_W)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(rd_ptr[ADDR_W-1:0]), .rdata(out_data)
  );

  rff_rd_track #(.DEPTH(DEPTH_WORDS)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clear), .commit(commit),
    .out_ready(out_ready), .head_len(out_data[LEN_W-1:0]),
    .out_valid(out_valid), .pkt_count(pkt_count), .rd_ptr(rd_ptr)
  );

  assign rx_irq = (pkt_count != '0);

  AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
    (we && out_valid) |-> (waddr != rd_ptr[ADDR_W-1:0])); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> (!out_valid && !ovf_flag && pkt_count == '0)); // R9
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !we && !fifo_clear) |=> $stable(out_data)); // R11
endmodule

// File: tb/rx_frame_fifo_test.sv
`timescale 1ns/1ps
module rx_frame_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_clear = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, rx_irq, ovf_flag;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic [9:0]  pkt_count;

  int errors = 0, checks = 0;
  bit done = 0;
  logic       rdy_after;
  logic [9:0] cnt_after;

  always #4 clk = ~clk;

  rx_frame_fifo uut (
    .clk(clk), .rst_n(rst_n), .fifo_clear(fifo_clear),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .pkt_count(pkt_count), .rx_irq(rx_irq), .ovf_flag(ovf_flag)
  );

  localparam int VEC_N = 8;
  localparam int VLEN  [VEC_N] = '{1, 2, 3, 4, 5, 6, 61, 64};
  localparam int VSEED [VEC_N] = '{8'h11, 8'h2a, 8'h33, 8'h40, 8'h5c, 8'h61, 8'h70, 8'h8f};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int seed, input int k);
    return 8'(seed + k * 7);
  endfunction

  function automatic logic [31:0] ew(input int n, input int seed, input int w);
    logic [31:0] r;
    int len;
    len = n + 2;
    for (int l = 0; l < 4; l++) begin
      int s;
      s = 4 * w + l;
      if (s < 2)          r[8*l +: 8] = 8'(len >> (8 * s));
      else if (s - 2 < n) r[8*l +: 8] = bval(seed, s - 2);
      else                r[8*l +: 8] = 8'h00;
    end
    return r;
  endfunction

  task automatic send_frame(input int n, input int seed, input int err_at, input bit close);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = bval(seed, k);
      in_sof   = (k == 0);
      in_eof   = close && (k == n - 1);
      in_err   = (k == err_at);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
    rdy_after = in_ready;
    cnt_after = pkt_count;
    @(negedge clk);
  endtask

  task automatic read_frame(input int n, input int seed, input int cnt_before, input string tag);
    int nw, bad_w;
    logic [31:0] bad_a, bad_e;
    bit cnt_bad;
    nw = (n + 5) / 4;
    bad_w = -1; cnt_bad = 0; bad_a = '0; bad_e = '0;
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      out_ready = 1'b0;
      while (!out_valid) @(negedge clk);
      if (pkt_count != 10'(cnt_before)) cnt_bad = 1;
      if (bad_w < 0 && out_data != ew(n, seed, w)) begin
        bad_w = w; bad_a = out_data; bad_e = ew(n, seed, w);
      end
      out_ready = 1'b1;
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(bad_w < 0, {tag, " R1 R2 R3 frame words"}, bad_a, bad_e);
    check(!cnt_bad && pkt_count == 10'(cnt_before - 1), "R5 count falls only after last word",
          32'(pkt_count), 32'(cnt_before - 1));
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    fifo_clear = 1'b1;
    @(negedge clk);
    fifo_clear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(pkt_count == 0 && !rx_irq && !out_valid && !ovf_flag && in_ready,
          "R12 reset state", {pkt_count, rx_irq, out_valid, ovf_flag, in_ready}, 32'h1);

    // table-driven frames of assorted lengths
    for (int v = 0; v < VEC_N; v++) begin
      send_frame(VLEN[v], VSEED[v], -1, 1'b1);
      check(!rdy_after && cnt_after == 0, "R4 seal cycle stalls, count unchanged",
            {rdy_after, cnt_after}, 32'h0);
      check(pkt_count == 1 && rx_irq, "R4 R6 count and irq after seal",
            {pkt_count, rx_irq}, {10'd1, 1'b1});
      read_frame(VLEN[v], VSEED[v], 1, "vec");
      check(!rx_irq && !out_valid, "R6 irq low when empty", {rx_irq, out_valid}, 32'h0);
    end

    // R11 hold while not ready; R5/R6 with several frames queued
    send_frame(9, 8'h21, -1, 1'b1);
    send_frame(3, 8'h44, -1, 1'b1);
    send_frame(14, 8'h99, -1, 1'b1);
    check(pkt_count == 3 && rx_irq, "R6 three frames queued", 32'(pkt_count), 32'd3);
    begin
      logic [31:0] first;
      bit moved;
      first = out_data; moved = 0;
      repeat (4) begin
        @(negedge clk);
        if (out_data != first) moved = 1;
      end
      check(!moved && first == ew(9, 8'h21, 0), "R11 data held under back-pressure", first, ew(9, 8'h21, 0));
    end
    read_frame(9, 8'h21, 3, "q1");
    read_frame(3, 8'h44, 2, "q2");
    read_frame(14, 8'h99, 1, "q3");

    // R8 error strobe mid frame and on the end beat
    send_frame(20, 8'h13, 7, 1'b1);
    check(pkt_count == 0 && !ovf_flag && !out_valid, "R8 errored frame dropped",
          {pkt_count, ovf_flag}, 32'h0);
    send_frame(9, 8'h17, 8, 1'b1);
    check(pkt_count == 0 && !ovf_flag, "R8 error on end beat dropped", {pkt_count, ovf_flag}, 32'h0);
    send_frame(11, 8'h5a, -1, 1'b1);
    read_frame(11, 8'h5a, 1, "R8 after-error");

    // R10 stray beats outside a frame
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'hee; in_sof = 1'b0; in_eof = (k == 2); in_err = 1'b0;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    repeat (2) @(negedge clk);
    check(pkt_count == 0 && !out_valid, "R10 stray beats ignored", 32'(pkt_count), 32'd0);
    // R10 restart: a partial frame with no end, then a new start
    send_frame(5, 8'h03, -1, 1'b0);
    send_frame(6, 8'h6b, -1, 1'b1);
    check(pkt_count == 1, "R10 restart yields one frame", 32'(pkt_count), 32'd1);
    read_frame(6, 8'h6b, 1, "R10 restart");

    // R7 exact fit: 3-word frame plus 2034 bytes fills all 512 words
    pulse_clear();
    send_frame(10, 8'h01, -1, 1'b1);
    send_frame(2034, 8'h02, -1, 1'b1);
    check(pkt_count == 2 && !ovf_flag, "R7 exact fit accepted", {pkt_count, ovf_flag}, {10'd2, 1'b0});
    read_frame(10, 8'h01, 2, "R7 fit A");
    read_frame(2034, 8'h02, 1, "R7 fit B");

    // R7 one byte past: overflow, drop, earlier frame intact, space reused
    pulse_clear();
    send_frame(10, 8'h31, -1, 1'b1);
    send_frame(2035, 8'h32, -1, 1'b1);
    check(pkt_count == 1 && ovf_flag, "R7 overflow flagged, count unchanged",
          {pkt_count, ovf_flag}, {10'd1, 1'b1});
    read_frame(10, 8'h31, 1, "R7 survivor");
    send_frame(7, 8'h4d, -1, 1'b1);
    check(ovf_flag, "R7 flag sticky", 32'(ovf_flag), 32'd1);
    read_frame(7, 8'h4d, 1, "R7 reuse");

    // R9 clear with frames queued
    send_frame(8, 8'h71, -1, 1'b1);
    send_frame(8, 8'h72, -1, 1'b1);
    pulse_clear();
    check(pkt_count == 0 && !out_valid && !rx_irq && !ovf_flag, "R9 clear empties",
          {pkt_count, out_valid, rx_irq, ovf_flag}, 32'h0);
    send_frame(5, 8'h90, -1, 1'b1);
    read_frame(5, 8'h90, 1, "R9 after clear");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule